// File: doc/BRIEF.md
# I2C SCL Ratio Clock Generator

This block produces the serial clock for an I2C controller from a faster reference clock. A programmable prescale value sets the length of one timing unit, which is `div + 1` reference cycles. A ratio select then decides how many units SCL spends low and how many high. The choices are a balanced 4:4 ratio for standard-mode rates, or the skewed 6:3 and 11:3 ratios for the fast modes. A skewed ratio gives the low phase the longer minimum time it needs without slowing the whole bit period.

The block drives SCL open-drain style: it asserts `scl_pull_low` during the low phase and otherwise releases the line. After a low phase it waits until the bus line, read back on `scl_in`, is actually high before it counts the high phase. A target that holds SCL low therefore stretches the clock. Four single-cycle strobes tell the bit engine where the phases begin and where their midpoints fall. The low midpoint is the point to change SDA and the high midpoint is the point to sample it. A synchronous enable stops the clock and clears every counter.

The controller is a four-state machine. IDLE goes to LOW on enable. LOW goes to WAIT_HI when its last unit ends. WAIT_HI goes to HIGH when `scl_in` is sampled high. HIGH goes to LOW when its last unit ends. Any state goes to IDLE when enable is low.

Top module: `scl_ratio_gen`

## Requirements
- R1: While reset is asserted, and while `enable` is low, `scl_pull_low`, `busy` and all four strobes are 0.
- R2: The first clock edge that sees `enable` high in IDLE starts a low phase: from that edge on, `scl_pull_low` and `busy` are 1.
- R3: `ratio_sel` encodes the low:high unit counts as follows: 0 gives 4:4, 1 gives 6:3, 2 gives 11:3, and 3 behaves exactly as 0.
- R4: One unit lasts `div + 1` reference cycles, so the low phase holds `scl_pull_low` for exactly n_low × (div + 1) cycles.
- R5: After the low phase, SCL is released and the block waits with its counters held for as long as `scl_in` samples low. This waiting state lasts at least one cycle. High-phase counting starts on the cycle after `scl_in` is first sampled high.
- R6: The high phase lasts n_high × (div + 1) cycles. The next low phase then begins at once, with no idle cycle between them.
- R7: `low_start_stb` pulses on the first cycle of each low phase, and `high_start_stb` pulses on the first counting cycle of each high phase.
- R8: `change_stb` pulses in low-phase cycle floor(n_low/2) × (div + 1), counted from 0. `sample_stb` pulses in high-phase cycle floor(n_high/2) × (div + 1), counted from 0.
- R9: `div` and `ratio_sel` are captured only at the edge that begins a low phase. A change at any other time takes effect at the next period.
- R10: Dropping `enable` returns the block to IDLE on the next edge and clears its counters. Re-enabling begins with a full low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable |
| div | input | DIV_W | Prescale value; one unit is div+1 cycles |
| ratio_sel | input | 2 | Low:high ratio select (0: 4:4, 1: 6:3, 2: 11:3, 3: 4:4) |
| scl_in | input | 1 | Sampled level of the SCL bus line |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| busy | output | 1 | Generator is running (not in IDLE) |
| low_start_stb | output | 1 | First cycle of a low phase |
| change_stb | output | 1 | Midpoint of the low phase (data change point) |
| high_start_stb | output | 1 | First counting cycle of a high phase |
| sample_stb | output | 1 | Midpoint of the high phase (sample point) |

## Verification
Two cases are the hardest to reach from the ports. The first is a change of `div` or `ratio_sel` that arrives part-way through a period, which must have no effect until the next low phase begins. The second is a stretch that covers the moment the low phase ends. The bench models the bus as a wired-AND of the block's pull-down and a target pull-down. It holds the target pull-down across several periods, so that the block sits in WAIT_HI for many cycles, and it also pulses it briefly. Configuration changes and an enable drop are placed at fixed cycles that land mid-phase under the running ratio. The reference model tracks elapsed cycles per phase, so any early or late capture shows up as a strobe or phase edge on the wrong cycle.

// File: rtl/scl_ratio_pkg.sv
package scl_ratio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_HI,
        ST_HIGH
    } scl_state_e;

    localparam int UNIT_W = 4;

    // Low-phase unit count for a ratio select code.
    function automatic logic [UNIT_W-1:0] low_units(input logic [1:0] sel);
        case (sel)
            2'd1:    return 4'd6;
            2'd2:    return 4'd11;
            default: return 4'd4;
        endcase
    endfunction

    // High-phase unit count for a ratio select code.
    function automatic logic [UNIT_W-1:0] high_units(input logic [1:0] sel);
        case (sel)
            2'd1, 2'd2: return 4'd3;
            default:    return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             at_first,
    output logic             at_last
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    assign at_first = (cnt_q == '0);
    assign at_last  = (cnt_q == limit);
endmodule

// File: rtl/scl_unit_counter.sv
module scl_unit_counter #(
    parameter int UNIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [UNIT_W-1:0] last_idx,
    output logic [UNIT_W-1:0] count,
    output logic              at_last
);
    logic [UNIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count   = cnt_q;
    assign at_last = (cnt_q == last_idx);
endmodule

// File: rtl/scl_ratio_gen.sv
module scl_ratio_gen
    import scl_ratio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    input  logic [1:0]       ratio_sel,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             busy,
    output logic             low_start_stb,
    output logic             change_stb,
    output logic             high_start_stb,
    output logic             sample_stb
);
    scl_state_e        state_q, state_d;
    logic [DIV_W-1:0]  div_q;
    logic [1:0]        sel_q;
    logic [UNIT_W-1:0] n_low, n_high, unit_last_idx, unit_cnt;
    logic              running, pre_first, pre_last, unit_last;
    logic              phase_last, cnt_clr, cfg_load;

    assign n_low         = low_units(sel_q);
    assign n_high        = high_units(sel_q);
    assign running       = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign unit_last_idx = (state_q == ST_LOW) ? n_low - 1'b1 : n_high - 1'b1;
    assign phase_last    = running && pre_last && unit_last;
    assign cnt_clr       = !enable || !running || phase_last;
    assign cfg_load      = enable && ((state_q == ST_IDLE) ||
                                      (state_q == ST_HIGH && phase_last));

    scl_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .run      (running),
        .limit    (div_q),
        .at_first (pre_first),
        .at_last  (pre_last)
    );

    scl_unit_counter #(.UNIT_W(UNIT_W)) u_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .step     (running && pre_last),
        .last_idx (unit_last_idx),
        .count    (unit_cnt),
        .at_last  (unit_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_LOW;
                ST_LOW:     if (phase_last) state_d = ST_WAIT_HI;
                ST_WAIT_HI: if (scl_in)     state_d = ST_HIGH;
                ST_HIGH:    if (phase_last) state_d = ST_LOW;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_load) begin
                div_q <= div;
                sel_q <= ratio_sel;
            end
        end
    end

    // Outputs
    always_comb begin
        scl_pull_low   = 1'b0;
        busy           = 1'b1;
        low_start_stb  = 1'b0;
        change_stb     = 1'b0;
        high_start_stb = 1'b0;
        sample_stb     = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_LOW: begin
                scl_pull_low  = 1'b1;
                low_start_stb = pre_first && (unit_cnt == '0);
                change_stb    = pre_first && (unit_cnt == (n_low >> 1));
            end
            ST_WAIT_HI: ;
            ST_HIGH: begin
                high_start_stb = pre_first && (unit_cnt == '0);
                sample_stb     = pre_first && (unit_cnt == (n_high >> 1));
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/scl_ratio_gen_chk.sv
module scl_ratio_gen_chk
    import scl_ratio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       scl_in,
    input logic       scl_pull_low,
    input logic       busy,
    input logic       low_start_stb,
    input logic       change_stb,
    input logic       high_start_stb,
    input logic       sample_stb,
    input scl_state_e state_q
);
    // R1, R10: disabling stops the clock on the next edge
    p_disable_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !scl_pull_low))
        else $error("p_disable_stops_r10");

    // R7, R8: at most one strobe per cycle
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start_stb, change_stb, high_start_stb, sample_stb}))
        else $error("p_strobe_excl_r8");

    // R2: a low phase can only begin under enable
    p_low_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> $past(enable))
        else $error("p_low_needs_en_r2");

    // R5: a held-low line keeps the block waiting
    p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HI && !scl_in && enable) |=> (state_q == ST_WAIT_HI))
        else $error("p_stretch_hold_r5");

    // R5: release after the low phase always passes through the wait state
    p_release_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull_low) |-> (!busy || state_q == ST_WAIT_HI))
        else $error("p_release_wait_r5");

    // R7: a low phase opens with its start strobe
    p_low_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> low_start_stb)
        else $error("p_low_opens_r7");
endmodule

bind scl_ratio_gen scl_ratio_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .scl_in         (scl_in),
    .scl_pull_low   (scl_pull_low),
    .busy           (busy),
    .low_start_stb  (low_start_stb),
    .change_stb     (change_stb),
    .high_start_stb (high_start_stb),
    .sample_stb     (sample_stb),
    .state_q        (state_q)
);

// File: tb/tb_scl_ratio_gen.sv
module tb_scl_ratio_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int N_CYCLES   = 760;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [1:0]       ratio_sel = '0;
    logic             scl_in = 1'b1;
    logic             scl_pull_low, busy, low_start_stb, change_stb;
    logic             high_start_stb, sample_stb;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit stretch = 1'b0;
    string tag = "R1";

    // Behavioural reference: 0 idle, 1 low, 2 wait, 3 high
    int m_st = 0, m_t = 0, m_div = 0, m_nl = 4, m_nh = 4;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_ratio_gen #(.DIV_W(DIV_W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .div            (div),
        .ratio_sel      (ratio_sel),
        .scl_in         (scl_in),
        .scl_pull_low   (scl_pull_low),
        .busy           (busy),
        .low_start_stb  (low_start_stb),
        .change_stb     (change_stb),
        .high_start_stb (high_start_stb),
        .sample_stb     (sample_stb)
    );

    function automatic int nl_of(input int s);
        return (s == 1) ? 6 : (s == 2) ? 11 : 4;   // R3
    endfunction
    function automatic int nh_of(input int s);
        return (s == 1 || s == 2) ? 3 : 4;          // R3
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int u;
        u = m_div + 1;
        check((tag == "R1") ? "R1" : "R4", "scl_pull_low", scl_pull_low, m_st == 1);
        check((tag == "R1") ? "R1" : "R2", "busy", busy, m_st != 0);
        check((tag == "R1") ? "R1" : "R7", "low_start_stb", low_start_stb, m_st == 1 && m_t == 0);
        check((tag == "R1") ? "R1" : "R7", "high_start_stb", high_start_stb, m_st == 3 && m_t == 0);
        check((tag == "R1") ? "R1" : "R8", "change_stb", change_stb,
              m_st == 1 && m_t == (m_nl / 2) * u);
        check((tag == "R1") ? "R1" : "R8", "sample_stb", sample_stb,
              m_st == 3 && m_t == (m_nh / 2) * u);
        if (tag != "R1")
            check(tag, "phase", scl_pull_low, m_st == 1);
    endtask

    task automatic model_step();
        if (!rst_n || !enable) begin
            m_st = 0; m_t = 0;
        end else begin
            case (m_st)
                0: begin
                    m_st = 1; m_t = 0;
                    m_div = int'(div); m_nl = nl_of(ratio_sel); m_nh = nh_of(ratio_sel);
                end
                1: if (m_t == m_nl * (m_div + 1) - 1) begin m_st = 2; m_t = 0; end
                   else m_t++;
                2: if (scl_in) begin m_st = 3; m_t = 0; end
                3: if (m_t == m_nh * (m_div + 1) - 1) begin
                       m_st = 1; m_t = 0;
                       m_div = int'(div); m_nl = nl_of(ratio_sel); m_nh = nh_of(ratio_sel);
                   end else m_t++;
                default: m_st = 0;
            endcase
        end
    endtask

    initial begin
        for (int c = 0; c < N_CYCLES; c++) begin
            @(negedge clk);
            compare_all();
            // stimulus schedule
            if (c == 4)   rst_n = 1'b1;
            if (c == 8)   begin tag = "R2"; enable = 1'b1; div = 8'd0; ratio_sel = 2'd0; end
            if (c == 40)  tag = "R4";
            if (c == 83)  begin tag = "R9"; div = 8'd2; ratio_sel = 2'd1; end   // mid-period change
            if (c == 200) begin tag = "R3"; div = 8'd1; ratio_sel = 2'd2; end
            if (c == 300) begin tag = "R5"; stretch = 1'b1; end                // long stretch
            if (c == 345) stretch = 1'b0;
            if (c == 400) begin tag = "R3"; div = 8'd0; ratio_sel = 2'd3; end  // reserved code
            if (c == 471) begin tag = "R10"; enable = 1'b0; end
            if (c == 475) begin enable = 1'b1; div = 8'd3; ratio_sel = 2'd1; end
            if (c == 560) tag = "R6";
            if (c >= 611 && c <= 616) stretch = 1'b1; else if (c > 616) stretch = 1'b0;
            if (c == 640) begin tag = "R9"; div = 8'd5; ratio_sel = 2'd0; end
            scl_in = !scl_pull_low && !stretch;
            model_step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule